// File: doc/BRIEF.md
# Codec Configuration Sequencer

This block brings an audio codec from its power-on program mode into streaming operation without software. Once `start` is pulsed, it sends a fixed, ordered series of 16-bit control writes through a word-level serial transceiver, one word for each completed exchange. `mode_mixed` selects one of two series: one ends in plain data mode, the other ends in mixed mode. The codec returns a word on every exchange. Those words are meaningless while the codec is still being programmed, so the sequencer drops them.

When the last control word has gone out, the sequencer raises `cfg_done` and switches the transmit path over to the DAC sample input. From then on every transmitted word is DAC data. Every received word is forwarded on `adc_sample` with a one-cycle `adc_valid` pulse. In mixed mode the ADC word that follows a control write can be corrupt, so a parameterised number of received words (`MIX_DROP`) is discarded before forwarding starts.

The controller has four states. `ST_IDLE` waits for start. `ST_PROGRAM` sends the control words. `ST_DRAIN` discards the suspect words in mixed mode. `ST_STREAM` passes DAC and ADC data. The transitions are:
- GO: `ST_IDLE` to `ST_PROGRAM` on `start`.
- NEXT: stay in `ST_PROGRAM` and step the word index on each exchange that is not the last.
- FINISH: on the last control exchange, leave `ST_PROGRAM` for `ST_DRAIN` (mixed mode with `MIX_DROP>0`) or for `ST_STREAM` (any other case).
- SETTLED: `ST_DRAIN` to `ST_STREAM` after `MIX_DROP` exchanges.

Top module: `codec_cfg_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `tx_req`, `cfg_done` and `adc_valid` are 0.
- R2: A `start` pulse in the idle state begins the series, and `mode_mixed` is captured at that moment (0 = data mode, 1 = mixed mode). A `start` pulse at any later time is ignored: the series under way, the selected mode and `cfg_done` are all unchanged.
- R3: Each control word is laid out as bit 15 = 1, bit 14 = 0 (write), bits 13:11 = device address `DEV_ADDR`, bits 10:8 = register address (A=0, B=1, C=2, D=3), bits 7:0 = data.
- R4: Data mode sends, in order: register B = 0x03, then register C = 0x01, then register A = 0x01. With device 0 these are 0x8103, 0x8201, 0x8001.
- R5: Mixed mode sends, in order: register A = 0x03, then B = 0x0F, then C = 0x01, then D = 0x20. With device 0 these are 0x8003, 0x810F, 0x8201, 0x8320.
- R6: The transmitted word moves to the next step only on a cycle with `xfer_done` = 1. Between exchanges it is held stable.
- R7: No received word produces `adc_valid` before `cfg_done` is high.
- R8: `cfg_done` rises in the cycle after the final control exchange and stays high until reset.
- R9: Once `cfg_done` is high, `tx_req` is 1 and `tx_word` equals `dac_sample`.
- R10: In mixed mode, the first `MIX_DROP` words received after the final control exchange are discarded. In data mode, no words are discarded after configuration.
- R11: In streaming, each exchange yields a one-cycle `adc_valid` pulse in the following cycle, with `adc_sample` equal to that exchange's `rx_word`.
- R12: A reset part-way through the series returns the sequencer to idle. The next start begins again at the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin configuration (honoured only when idle) |
| mode_mixed | input | 1 | 0 selects data mode, 1 selects mixed mode; captured at start |
| tx_req | output | 1 | A word is offered to the transceiver |
| tx_word | output | 16 | Word to send (control word or DAC sample) |
| xfer_done | input | 1 | Transceiver completed one exchange this cycle |
| rx_word | input | 16 | Word received in the exchange that completes |
| dac_sample | input | 16 | DAC sample to send once configured |
| adc_sample | output | 16 | Forwarded ADC sample |
| adc_valid | output | 1 | `adc_sample` holds a new valid sample |
| cfg_done | output | 1 | Configuration series complete |

## Verification
The bench builds two copies side by side from the same stimulus. The first uses the defaults (device address 0, one discarded word). The second uses device address 5 and two discarded words, so the device field is exercised with nonzero bits and the drain state runs a multi-step count rather than a single cycle. Running both copies in lockstep also shows that the drain length changes only which received words are forwarded, and leaves the control series and the hand-over point unchanged.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

    localparam int WORD_W    = 16;
    localparam int MAX_STEPS = 4;
    localparam int STEP_W    = $clog2(MAX_STEPS);

    localparam logic [2:0] REG_A = 3'd0;
    localparam logic [2:0] REG_B = 3'd1;
    localparam logic [2:0] REG_C = 3'd2;
    localparam logic [2:0] REG_D = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PROGRAM = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_STREAM  = 2'd3
    } seq_state_t;

    // Packs a control write: marker, write flag, device, register, data
    function automatic logic [WORD_W-1:0] ctrl_write(input logic [2:0] dev,
                                                     input logic [2:0] reg_sel,
                                                     input logic [7:0] data);
        return {1'b1, 1'b0, dev, reg_sel, data};
    endfunction

endpackage

// File: rtl/cfg_word_table.sv
module cfg_word_table
    import codec_cfg_pkg::*;
#(
    parameter logic [2:0] DEV = 3'd0
) (
    input  logic              mixed,
    input  logic [STEP_W-1:0] idx,
    output logic [WORD_W-1:0] word,
    output logic              last
);
    always_comb begin
        word = '0;
        if (mixed) begin
            unique case (idx)
                2'd0: word = ctrl_write(DEV, REG_A, 8'h03);
                2'd1: word = ctrl_write(DEV, REG_B, 8'h0F);
                2'd2: word = ctrl_write(DEV, REG_C, 8'h01);
                2'd3: word = ctrl_write(DEV, REG_D, 8'h20);
            endcase
            last = (idx == 2'd3);
        end else begin
            unique case (idx)
                2'd0: word = ctrl_write(DEV, REG_B, 8'h03);
                2'd1: word = ctrl_write(DEV, REG_C, 8'h01);
                2'd2: word = ctrl_write(DEV, REG_A, 8'h01);
                2'd3: word = '0;
            endcase
            last = (idx == 2'd2);
        end
    end
endmodule

// File: rtl/cfg_step_ctr.sv
module cfg_step_ctr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else if (adv) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/adc_out_reg.sv
module adc_out_reg
    import codec_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] data_in,
    output logic              valid,
    output logic [WORD_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= capture;
            if (capture) begin
                data <= data_in;
            end
        end
    end
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
    import codec_cfg_pkg::*;
#(
    parameter int DEV_ADDR = 0,
    parameter int MIX_DROP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_mixed,
    output logic              tx_req,
    output logic [WORD_W-1:0] tx_word,
    input  logic              xfer_done,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [WORD_W-1:0] dac_sample,
    output logic [WORD_W-1:0] adc_sample,
    output logic              adc_valid,
    output logic              cfg_done
);
    localparam logic [2:0] DEV    = DEV_ADDR[2:0];
    localparam int         DROP_W = (MIX_DROP > 1) ? $clog2(MIX_DROP) : 1;

    seq_state_t        state_q, state_d;
    logic              mixed_q;
    logic [STEP_W-1:0] step;
    logic [WORD_W-1:0] cfg_word;
    logic              cfg_last;
    logic              drop_last;
    logic              step_adv;

    cfg_word_table #(.DEV(DEV)) u_table (
        .mixed (mixed_q),
        .idx   (step),
        .word  (cfg_word),
        .last  (cfg_last)
    );

    assign step_adv = (state_q == ST_PROGRAM) && xfer_done && !cfg_last;

    cfg_step_ctr #(.W(STEP_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_IDLE),
        .adv   (step_adv),
        .count (step)
    );

    generate
        if (MIX_DROP > 0) begin : g_drop
            logic [DROP_W-1:0] drop_cnt;
            cfg_step_ctr #(.W(DROP_W)) u_drop (
                .clk   (clk),
                .rst_n (rst_n),
                .clear (state_q != ST_DRAIN),
                .adv   (xfer_done),
                .count (drop_cnt)
            );
            assign drop_last = (drop_cnt == DROP_W'(MIX_DROP - 1));
        end else begin : g_nodrop
            assign drop_last = 1'b1;
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mixed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                mixed_q <= mode_mixed;
            end
        end
    end

    // Transitions: GO, NEXT, FINISH, SETTLED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_PROGRAM;
            end
            ST_PROGRAM: begin
                if (xfer_done && cfg_last) begin
                    state_d = (mixed_q && MIX_DROP > 0) ? ST_DRAIN : ST_STREAM;
                end
            end
            ST_DRAIN: begin
                if (xfer_done && drop_last) state_d = ST_STREAM;
            end
            ST_STREAM: begin
                state_d = ST_STREAM;
            end
        endcase
    end

    // Outputs
    always_comb begin
        tx_req   = 1'b0;
        tx_word  = '0;
        cfg_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tx_req = 1'b0;
            end
            ST_PROGRAM: begin
                tx_req  = 1'b1;
                tx_word = cfg_word;
            end
            ST_DRAIN, ST_STREAM: begin
                tx_req   = 1'b1;
                tx_word  = dac_sample;
                cfg_done = 1'b1;
            end
        endcase
    end

    adc_out_reg u_adc (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture ((state_q == ST_STREAM) && xfer_done),
        .data_in (rx_word),
        .valid   (adc_valid),
        .data    (adc_sample)
    );
endmodule

// File: rtl/codec_cfg_seq_chk.sv
module codec_cfg_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mode_mixed,
    input logic        tx_req,
    input logic [15:0] tx_word,
    input logic        xfer_done,
    input logic [15:0] rx_word,
    input logic [15:0] dac_sample,
    input logic [15:0] adc_sample,
    input logic        adc_valid,
    input logic        cfg_done
);
    // R7
    no_early_adc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |-> cfg_done);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    // R11
    adc_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_valid |-> ($past(xfer_done) && adc_sample == $past(rx_word)));

    // R3
    ctrl_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !cfg_done) |-> (tx_word[15:14] == 2'b10));

    // R6
    word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !cfg_done && !xfer_done) |=> (cfg_done || $stable(tx_word)));

    // R9
    dac_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> (tx_req && tx_word == dac_sample));

    // R2
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(start) && !$past(tx_req)) |->
        (tx_word[10:0] == ($past(mode_mixed) ? 11'h003 : 11'h103)));
endmodule

bind codec_cfg_seq codec_cfg_seq_chk u_chk (.*);

// File: tb/codec_cfg_seq_bench.sv
module codec_cfg_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode_mixed = 1'b0;
    logic        xfer_done = 1'b0;
    logic [15:0] rx_word = '0;
    logic [15:0] dac_sample = '0;

    logic        treq_a, treq_b, done_a, done_b, av_a, av_b;
    logic [15:0] tw_a, tw_b, as_a, as_b;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    codec_cfg_seq u_codec_cfg_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_mixed(mode_mixed),
        .tx_req(treq_a), .tx_word(tw_a), .xfer_done(xfer_done), .rx_word(rx_word),
        .dac_sample(dac_sample), .adc_sample(as_a), .adc_valid(av_a), .cfg_done(done_a)
    );

    codec_cfg_seq #(.DEV_ADDR(5), .MIX_DROP(2)) u_alt (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_mixed(mode_mixed),
        .tx_req(treq_b), .tx_word(tw_b), .xfer_done(xfer_done), .rx_word(rx_word),
        .dac_sample(dac_sample), .adc_sample(as_b), .adc_valid(av_b), .cfg_done(done_b)
    );

    function automatic logic [15:0] exp_ctrl(input int dev, input logic mixed, input int k);
        logic [2:0] r;
        logic [7:0] d;
        if (mixed) begin
            r = 3'(k);
            d = (k == 0) ? 8'h03 : (k == 1) ? 8'h0F : (k == 2) ? 8'h01 : 8'h20;
        end else begin
            r = (k == 0) ? 3'd1 : (k == 1) ? 3'd2 : 3'd0;
            d = (k == 0) ? 8'h03 : 8'h01;
        end
        return {1'b1, 1'b0, 3'(dev), r, d};
    endfunction

    function automatic int seq_len(input logic mixed);
        return mixed ? 4 : 3;
    endfunction

    task automatic check(input logic ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    task automatic pre_chk(input string tag, input logic treq, input logic [15:0] tw,
                           input logic done, input logic mixed, input int k,
                           input int dev);
        int len = seq_len(mixed);
        check(treq == 1'b1, {tag, " R9 tx_req"}, 16'(treq), 16'd1);
        if (k < len) begin
            check(tw == exp_ctrl(dev, mixed, k), mixed ? {tag, " R5 R3 word"} : {tag, " R4 R3 word"},
                  tw, exp_ctrl(dev, mixed, k));
            check(done == 1'b0, {tag, " R8 done low"}, 16'(done), 16'd0);
        end else begin
            check(tw == dac_sample, {tag, " R9 dac path"}, tw, dac_sample);
            check(done == 1'b1, {tag, " R8 done high"}, 16'(done), 16'd1);
        end
    endtask

    task automatic post_chk(input string tag, input logic av, input logic [15:0] as_,
                            input logic done, input logic mixed, input int k,
                            input int drop);
        int len = seq_len(mixed);
        int d = mixed ? drop : 0;
        logic ev = (k >= len + d);
        string rq = (k < len) ? " R7" : (ev ? " R11" : " R10");
        check(av == ev, {tag, rq, " adc_valid"}, 16'(av), 16'(ev));
        if (ev) check(as_ == rx_word, {tag, " R11 adc_sample"}, as_, rx_word);
        check(done == (k >= len - 1), {tag, " R8 done after exchange"}, 16'(done),
              16'(k >= len - 1));
    endtask

    task automatic xchg(input logic mixed, input int k);
        logic [15:0] rx = 16'($urandom);
        @(negedge clk);
        dac_sample = 16'($urandom);
        #1;
        pre_chk("A", treq_a, tw_a, done_a, mixed, k, 0);
        pre_chk("B", treq_b, tw_b, done_b, mixed, k, 5);
        xfer_done = 1'b1;
        rx_word = rx;
        @(negedge clk);
        xfer_done = 1'b0;
        #1;
        post_chk("A", av_a, as_a, done_a, mixed, k, 1);
        post_chk("B", av_b, as_b, done_b, mixed, k, 2);
    endtask

    task automatic gap(input int cycles);
        logic [15:0] held = tw_a;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            #1;
            check(av_a == 1'b0 && av_b == 1'b0, "R11 no pulse without exchange",
                  16'(av_a), 16'd0);
            if (!done_a) check(tw_a == held, "R6 word held", tw_a, held);
        end
    endtask

    task automatic pulse_start(input logic m);
        @(negedge clk);
        start = 1'b1;
        mode_mixed = m;
        @(negedge clk);
        start = 1'b0;
        mode_mixed = $urandom_range(0, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        xfer_done = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(treq_a == 0 && done_a == 0 && av_a == 0, "R1 R12 outputs in reset",
              {13'd0, treq_a, done_a, av_a}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(treq_a == 0 && done_a == 0 && av_a == 0 && treq_b == 0 && done_b == 0,
              "R1 outputs after reset", {13'd0, treq_a, done_a, av_a}, 16'd0);
    endtask

    task automatic run_seq(input logic mixed, input int total, input int poke_at);
        pulse_start(mixed);
        for (int k = 0; k < total; k++) begin
            xchg(mixed, k);
            if (k == poke_at) begin
                pulse_start(~mixed);
                #1;
                check(tw_a == exp_ctrl(0, mixed, k + 1), "R2 start ignored while busy",
                      tw_a, exp_ctrl(0, mixed, k + 1));
            end
            gap($urandom_range(0, 3));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R6 actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'h0C0DEC5));
        do_reset();
        // R4 data mode, directed
        run_seq(1'b0, 9, -1);
        // R2 start after completion ignored
        pulse_start(1'b1);
        #1;
        check(done_a == 1'b1 && tw_a == dac_sample, "R2 R8 start after done ignored",
              tw_a, dac_sample);
        // R5 R10 mixed mode with a start pulse during programming
        do_reset();
        run_seq(1'b1, 10, 1);
        // R12 reset part-way through, then restart
        do_reset();
        pulse_start(1'b1);
        xchg(1'b1, 0);
        xchg(1'b1, 1);
        do_reset();
        run_seq(1'b0, 6, -1);
        // Random runs
        for (int r = 0; r < 8; r++) begin
            logic m = 1'($urandom_range(0, 1));
            do_reset();
            run_seq(m, $urandom_range(7, 14), -1);
        end
        finish_up();
    end
endmodule